// File: doc/BRIEF.md
# Indexed Palette RAM Loader

This block holds a colour lookup table of 256 entries. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the table through two pre-decoded write strobes that share one data bus. The index strobe selects a starting entry. The colour strobe delivers component bytes. A sequencer inside the block sends each byte to the red, green or blue slot of the current entry. After a blue byte it moves on to the next entry. A 32-bit colour write is split into four component bytes, and all four are stored in the same clock cycle.

A second, read-only port turns an 8-bit pixel value into a packed 24-bit colour, combinationally. A display pipeline reads through this port while software loads the table. A sticky flag records that the palette has changed, so the display logic knows it must redraw the next frame in full. The display side clears the flag with a frame-done pulse.

Top module: `clut_loader`

## Requirements
- R1: While reset is asserted, every table entry becomes zero, the component phase becomes red and the current index becomes 0.
- R2: A pulse on `wr_idx` loads `wdata[7:0]` into the current index and forces the phase back to red, whatever the phase was before.
- R3: A byte colour write (`wr_col`=1, `wr_word`=0) stores `wdata[7:0]` into exactly one component of the current entry. The phase chooses the component: 0 = red, 1 = green, 2 = blue. The phase then advances by one.
- R4: After a blue byte is stored, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R5: A word colour write (`wr_col`=1, `wr_word`=1) acts as four consecutive byte steps, taking bytes in the order `wdata[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. All four steps complete in one clock edge.
- R6: `pix_rgb` equals {8'h00, red[p], green[p], blue[p]} for `p` = `pix_idx`, combinationally. Using the lookup port never changes the phase, the index or the table.
- R7: `pal_dirty` is 1 after reset. It is set by every accepted colour write and cleared by `frame_done`. When both occur on the same edge, set wins.
- R8: When `wr_idx` and `wr_col` are high in the same cycle, the index write takes effect and the colour byte or bytes are discarded. That cycle does not set `pal_dirty`.
- R9: `rdata`, the read value of both loader registers, is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_idx | input | 1 | Write strobe for the index register |
| wr_col | input | 1 | Write strobe for the colour-data register |
| wr_word | input | 1 | 1 = 32-bit colour write, 0 = byte write |
| wdata | input | 32 | Shared write data |
| frame_done | input | 1 | Clears the palette-changed flag |
| rdata | output | 32 | Read data of both registers (always zero) |
| pix_idx | input | 8 | Pixel value for lookup |
| pix_rgb | output | 32 | Looked-up colour, 0x00RRGGBB |
| pal_dirty | output | 1 | Palette-changed flag |

## Verification
A write strobed before a rising edge updates the table, the phase and the index on that edge. The new colour therefore appears on `pix_rgb` within the same clock, because the lookup adds no register. `pal_dirty` likewise reflects a write or a clear one edge after the strobe. The bench drives strobes on falling edges and holds them for one full period. It then samples the flag and the lookup results at the following falling edge, plus 1 ns once the lookup index has settled. The bench keeps a reference model of the table and the sequencer, built from the requirements, and compares every entry against it after each scenario.

// File: rtl/clut_pkg.sv
package clut_pkg;
   localparam logic [1:0] PH_RED = 2'd0;
   localparam logic [1:0] PH_GRN = 2'd1;
   localparam logic [1:0] PH_BLU = 2'd2;
   localparam int unsigned PHASES = 3;

   typedef logic [7:0] comp_t;

   function automatic logic [31:0] pack_rgb(input comp_t r, input comp_t g, input comp_t b);
      return {8'h00, r, g, b};
   endfunction
endpackage

// File: rtl/clut_step_unroll.sv
// Expands one colour write into up to SLOTS component steps and
// computes the sequencer state that follows them.
module clut_step_unroll
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned BUS_W = 32,
   localparam int unsigned SLOTS = BUS_W / 8
) (
   input  logic [1:0]             ph_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic                   word_i,
   input  logic [BUS_W-1:0]       data_i,
   output logic [SLOTS-1:0]       slot_vld,
   output logic [SLOTS-1:0][1:0]  slot_ph,
   output logic [SLOTS-1:0][IDX_W-1:0] slot_idx,
   output logic [SLOTS-1:0][7:0]  slot_byte,
   output logic [1:0]             ph_o,
   output logic [IDX_W-1:0]       idx_o
);
   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      int sum;
      always_comb begin
         sum         = int'(ph_i) + k;
         slot_ph[k]  = 2'(sum % PHASES);
         slot_idx[k] = idx_i + IDX_W'(sum / PHASES);
      end
      assign slot_vld[k]  = (k == 0) || word_i;
      // word mode: most significant byte is the first step
      assign slot_byte[k] = word_i ? data_i[BUS_W-1-8*k -: 8] : data_i[7:0];
   end

   int nsum;
   always_comb begin
      nsum  = int'(ph_i) + (word_i ? int'(SLOTS) : 1);
      ph_o  = 2'(nsum % PHASES);
      idx_o = idx_i + IDX_W'(nsum / PHASES);
   end
endmodule

// File: rtl/clut_store.sv
// Flop-based three-component table: multi-slot write, one combinational read.
module clut_store
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned SLOTS = 4,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en_i,
   input  logic [SLOTS-1:0]            slot_vld,
   input  logic [SLOTS-1:0][1:0]       slot_ph,
   input  logic [SLOTS-1:0][IDX_W-1:0] slot_idx,
   input  logic [SLOTS-1:0][7:0]       slot_byte,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [31:0]                 rd_rgb
);
   comp_t red [DEPTH];
   comp_t grn [DEPTH];
   comp_t blu [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) begin
            red[e] <= '0;
            grn[e] <= '0;
            blu[e] <= '0;
         end
      end else if (en_i) begin
         for (int k = 0; k < SLOTS; k++) begin
            if (slot_vld[k]) begin
               case (slot_ph[k])
                  PH_RED:  red[slot_idx[k]] <= slot_byte[k];
                  PH_GRN:  grn[slot_idx[k]] <= slot_byte[k];
                  default: blu[slot_idx[k]] <= slot_byte[k];
               endcase
            end
         end
      end
   end

   assign rd_rgb = pack_rgb(red[rd_idx], grn[rd_idx], blu[rd_idx]);
endmodule

// File: rtl/clut_loader.sv
module clut_loader
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_idx,
   input  logic             wr_col,
   input  logic             wr_word,
   input  logic [BUS_W-1:0] wdata,
   input  logic             frame_done,
   output logic [BUS_W-1:0] rdata,
   input  logic [IDX_W-1:0] pix_idx,
   output logic [31:0]      pix_rgb,
   output logic             pal_dirty
);
   localparam int unsigned SLOTS = BUS_W / 8;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("clut_loader: IDX_W must be 1..8");
   end
   if (BUS_W < 8 || (BUS_W % 8) != 0) begin : g_bad_bus
      $error("clut_loader: BUS_W must be a positive multiple of 8");
   end

   logic [1:0]       ph_q, ph_nxt;
   logic [IDX_W-1:0] idx_q, idx_nxt;
   logic             col_acc;

   logic [SLOTS-1:0]            s_vld;
   logic [SLOTS-1:0][1:0]       s_ph;
   logic [SLOTS-1:0][IDX_W-1:0] s_idx;
   logic [SLOTS-1:0][7:0]       s_byte;

   // index write has priority over a colour write in the same cycle
   assign col_acc = wr_col & ~wr_idx;

   clut_step_unroll #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_step (
      .ph_i     (ph_q),
      .idx_i    (idx_q),
      .word_i   (wr_word),
      .data_i   (wdata),
      .slot_vld (s_vld),
      .slot_ph  (s_ph),
      .slot_idx (s_idx),
      .slot_byte(s_byte),
      .ph_o     (ph_nxt),
      .idx_o    (idx_nxt)
   );

   clut_store #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (col_acc),
      .slot_vld (s_vld),
      .slot_ph  (s_ph),
      .slot_idx (s_idx),
      .slot_byte(s_byte),
      .rd_idx   (pix_idx),
      .rd_rgb   (pix_rgb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_RED;
         idx_q <= '0;
      end else if (wr_idx) begin
         ph_q  <= PH_RED;
         idx_q <= wdata[IDX_W-1:0];
      end else if (wr_col) begin
         ph_q  <= ph_nxt;
         idx_q <= idx_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          pal_dirty <= 1'b1;
      else if (col_acc)    pal_dirty <= 1'b1;
      else if (frame_done) pal_dirty <= 1'b0;
   end

   assign rdata = '0;
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned BUS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_idx,
   input logic             wr_col,
   input logic             wr_word,
   input logic [BUS_W-1:0] wdata,
   input logic             pal_dirty,
   input logic [1:0]       cur_ph,
   input logic [IDX_W-1:0] cur_idx
);
   localparam int SL = BUS_W / 8;

   logic [1:0]       w_ph;
   logic [IDX_W-1:0] w_idx;
   always_comb begin
      w_ph  = 2'((int'(cur_ph) + SL) % 3);
      w_idx = cur_idx + IDX_W'((int'(cur_ph) + SL) / 3);
   end

   p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ph != 2'd3);

   p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idx |=> (cur_ph == 2'd0) && (cur_idx == $past(wdata[IDX_W-1:0])));

   p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_col && !wr_idx && !wr_word && cur_ph != 2'd2) |=> cur_ph == $past(cur_ph) + 2'd1);

   p_blue_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_col && !wr_idx && !wr_word && cur_ph == 2'd2) |=>
         (cur_ph == 2'd0) && (cur_idx == $past(cur_idx) + 1'b1));

   p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_col && !wr_idx && wr_word) |=> (cur_ph == $past(w_ph)) && (cur_idx == $past(w_idx)));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_idx && !wr_col) |=> $stable(cur_ph) && $stable(cur_idx));

   p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_col && !wr_idx) |=> pal_dirty);

   p_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_col && wr_idx) |=> cur_ph == 2'd0);
endmodule

bind clut_loader clut_loader_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_idx   (wr_idx),
   .wr_col   (wr_col),
   .wr_word  (wr_word),
   .wdata    (wdata),
   .pal_dirty(pal_dirty),
   .cur_ph   (ph_q),
   .cur_idx  (idx_q)
);

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_idx = 1'b0, wr_col = 1'b0, wr_word = 1'b0, frame_done = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, pix_rgb;
   logic [7:0]  pix_idx = '0;
   logic        pal_dirty;

   always #5 clk = ~clk;

   clut_loader u0 (
      .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wr_col(wr_col), .wr_word(wr_word),
      .wdata(wdata), .frame_done(frame_done), .rdata(rdata), .pix_idx(pix_idx),
      .pix_rgb(pix_rgb), .pal_dirty(pal_dirty)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] mr [256], mg [256], mb [256];
   int  mph = 0;
   logic [7:0] midx = '0;
   bit  mdirty = 1'b1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one write cycle; model updated from the requirements
   task automatic wr(input bit ie, input bit ce, input bit wd, input bit fd, input logic [31:0] d);
      @(negedge clk);
      wr_idx = ie; wr_col = ce; wr_word = wd; frame_done = fd; wdata = d;
      chk(rdata == 32'h0, "R9 rdata", rdata, 32'h0);
      @(negedge clk);
      wr_idx = 0; wr_col = 0; wr_word = 0; frame_done = 0;
      if (ie) begin
         midx = d[7:0]; mph = 0;
      end else if (ce) begin
         for (int k = 0; k < (wd ? 4 : 1); k++) begin
            logic [7:0] b;
            b = wd ? d[31-8*k -: 8] : d[7:0];
            case (mph)
               0: mr[midx] = b;
               1: mg[midx] = b;
               default: mb[midx] = b;
            endcase
            mph++;
            if (mph == 3) begin mph = 0; midx = midx + 8'd1; end
         end
      end
      if (ce && !ie) mdirty = 1'b1;
      else if (fd)   mdirty = 1'b0;
   endtask

   task automatic look(input logic [7:0] p, input string req);
      pix_idx = p;
      #1;
      chk(pix_rgb == {8'h00, mr[p], mg[p], mb[p]}, req, pix_rgb, {8'h00, mr[p], mg[p], mb[p]});
   endtask

   task automatic look_all(input string req);
      for (int e = 0; e < 256; e++) look(8'(e), req);
   endtask

   task automatic chk_dirty(input string req);
      chk(pal_dirty == mdirty, req, {31'h0, pal_dirty}, {31'h0, mdirty});
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int e = 0; e < 256; e++) begin mr[e] = 0; mg[e] = 0; mb[e] = 0; end
      // make sure reset clears even non-zero content: load some first
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wr(0, 1, 1, 0, 32'hDEADBEEF);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      for (int e = 0; e < 256; e++) begin mr[e] = 0; mg[e] = 0; mb[e] = 0; end
      mph = 0; midx = 0; mdirty = 1;
      // R1: table cleared, dirty set by reset (R7)
      look_all("R1 reset table");
      chk_dirty("R7 reset flag");

      // R5/R4: fill whole table with 192 word writes from index 0 (no explicit index write: R1 index 0)
      for (int w = 0; w < 192; w++) begin
         logic [31:0] d;
         for (int k = 0; k < 4; k++) d[31-8*k -: 8] = 8'((w*4 + k) * 37 + 11);
         wr(0, 1, 1, 0, d);
      end
      look_all("R5 word fill");

      // R7: clear flag, then colour write sets, then set wins over clear
      wr(0, 0, 0, 1, 32'h0);
      chk_dirty("R7 clear");
      wr(1, 0, 0, 0, 32'h05);
      chk_dirty("R7 index write leaves flag");
      wr(0, 1, 0, 0, 32'h3C);
      chk_dirty("R7 set");
      wr(0, 1, 0, 1, 32'h3D);
      chk_dirty("R7 set wins");

      // R3: byte steps one component each
      wr(1, 0, 0, 0, 32'h0A);
      wr(0, 1, 0, 0, 32'hFFFF_FF11);
      look(8'h0A, "R3 red only");
      look(8'h0B, "R3 neighbour untouched");
      wr(0, 1, 0, 0, 32'h22);
      look(8'h0A, "R3 green");
      wr(0, 1, 0, 0, 32'h33);
      look(8'h0A, "R3 blue");
      wr(0, 1, 0, 0, 32'h44);
      look(8'h0B, "R4 next entry red");

      // R4: wrap 255 -> 0
      wr(1, 0, 0, 0, 32'hFF);
      wr(0, 1, 0, 0, 32'h91);
      wr(0, 1, 0, 0, 32'h92);
      wr(0, 1, 0, 0, 32'h93);
      wr(0, 1, 0, 0, 32'h94);
      look(8'hFF, "R4 entry 255");
      look(8'h00, "R4 wrap to 0");

      // R2: index write mid-sequence restarts at red
      wr(1, 0, 0, 0, 32'h14);
      wr(0, 1, 0, 0, 32'hA1);
      wr(1, 0, 0, 0, 32'h14);
      wr(0, 1, 0, 0, 32'hA2);
      look(8'h14, "R2 restart red");

      // R5: word starting at green phase crosses into next entry
      wr(1, 0, 0, 0, 32'h1E);
      wr(0, 1, 0, 0, 32'h01);
      wr(0, 1, 1, 0, 32'hC1C2C3C4);
      look(8'h1E, "R5 tail of entry");
      look(8'h1F, "R5 head of next");
      wr(0, 1, 0, 0, 32'h77);
      look(8'h1F, "R5 phase after word");

      // R8: collision drops colour, loads index, flag untouched
      wr(0, 0, 0, 1, 32'h0);
      wr(1, 1, 0, 0, 32'h28);
      chk_dirty("R8 flag not set");
      look(8'h28, "R8 colour dropped");
      wr(0, 1, 0, 0, 32'hAB);
      look(8'h28, "R8 index from collision");

      // R6: lookups sweep mid-sequence, then sequencer continues unchanged
      wr(0, 1, 0, 0, 32'hBC);
      look_all("R6 sweep");
      wr(0, 1, 0, 0, 32'hCD);
      look(8'h28, "R6 sequencer unaffected");
      look(8'h29, "R6 next untouched");

      look_all("R5 final table");
      summary();
      $finish;
   end
endmodule